// File: doc/BRIEF.md
# 720p Raster Timing Generator

This block runs on the pixel clock and walks a 1280x720 progressive raster. It counts pixels along a line and lines down a frame. From those counts it derives horizontal and vertical sync, a flag that marks the visible region, a one-cycle strobe at the start of every frame, and a frame counter that wraps every sixty frames. Downstream pixel generators use the counters as screen coordinates. Link encoders use the active flag to choose between pixel data and control periods.

Every output comes from a flop. The sync, active and new-frame flags always describe the counter values presented in the same cycle. The porch and sync widths are parameters. By default they give the standard 720p60 raster: 1650 pixels by 750 lines, with active-high syncs.

Top module: `video_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `hCount`, `vCount` and `frameCount` become 0, and `hSync`, `vSync`, `activeDraw` and `newFrame` become 0.
- R2: After reset, `hCount` increases by one on every clock. It returns to 0 after the value H_TOTAL-1, which is 1649 by default.
- R3: `vCount` changes only on the clock where `hCount` goes from H_TOTAL-1 to 0. On that clock it increases by one, or goes to 0 after V_TOTAL-1, which is 749 by default.
- R4: `activeDraw` is 1 exactly when `hCount` < 1280 and `vCount` < 720, and 0 during blanking and sync.
- R5: `hSync` is active-high. It is 1 exactly when 1390 <= `hCount` < 1430: 110 pixels of front porch, then 40 of sync, then 220 of back porch.
- R6: `vSync` is active-high. It is 1 exactly when 725 <= `vCount` < 730: 5 lines of front porch, then 5 of sync, then 20 of back porch.
- R7: `newFrame` is 1 for exactly one clock per frame, on the cycle where the counters have just wrapped to `hCount`=0, `vCount`=0. The 0,0 state produced by reset does not raise it.
- R8: `frameCount` advances on the same clock as `newFrame`, counting 0 to 59 and then returning to 0. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (74.25 MHz in use) |
| rst | input | 1 | Synchronous reset, active high |
| hCount | output | 11 | Pixel position within the line |
| vCount | output | 10 | Line position within the frame |
| hSync | output | 1 | Horizontal sync, active high |
| vSync | output | 1 | Vertical sync, active high |
| activeDraw | output | 1 | High inside the visible region |
| newFrame | output | 1 | One-clock strobe on the first pixel of a frame |
| frameCount | output | 6 | Frame index, 0 to 59 |

## Verification
The bench shrinks the raster through its parameters to 25 pixels by 14 lines, with porch and sync widths of a few units each. It then compares every output on every clock against positions computed arithmetically from the cycle count since reset. A run longer than sixty frames covers every pixel position many times, every sync and active edge, and the 59-to-0 frame wrap. A reset in the middle of a frame separates a true wrap to 0,0 from a reset to 0,0, and shows that `newFrame` follows only the wrap. Checking every output in the same cycle also catches any output that lags or leads the counters by one clock.

// File: rtl/video_timing_pkg.sv
package video_timing_pkg;
  typedef struct packed {
    logic hEnd;   // horizontal counter at last pixel of line
    logic vEnd;   // vertical counter at last line of frame
    logic fEnd;   // frame counter at last frame index
  } rasterStrobes_t;
endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import video_timing_pkg::*;
#(
  parameter int HW        = 11,
  parameter int VW        = 10,
  parameter int FW        = 6,
  parameter int H_TOTAL   = 1650,
  parameter int V_TOTAL   = 750,
  parameter int FRAME_MOD = 60
) (
  input  logic [HW-1:0]  hCount,
  input  logic [VW-1:0]  vCount,
  input  logic [FW-1:0]  frameCount,
  output rasterStrobes_t strobes
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [FW-1:0] F_LAST = FW'(FRAME_MOD - 1);

  always_comb begin
    strobes.hEnd = (hCount == H_LAST);
    strobes.vEnd = (vCount == V_LAST);
    strobes.fEnd = (frameCount == F_LAST);
  end
endmodule

// File: rtl/raster_decode.sv
module raster_decode #(
  parameter int HW       = 11,
  parameter int VW       = 10,
  parameter int H_ACTIVE = 1280,
  parameter int H_FRONT  = 110,
  parameter int H_SYNC   = 40,
  parameter int V_ACTIVE = 720,
  parameter int V_FRONT  = 5,
  parameter int V_SYNC   = 5
) (
  input  logic [HW-1:0] hPos,
  input  logic [VW-1:0] vPos,
  output logic          activeFlag,
  output logic          hSyncFlag,
  output logic          vSyncFlag
);
  localparam logic [HW-1:0] H_VIS_END  = HW'(H_ACTIVE);
  localparam logic [HW-1:0] H_SYNC_BEG = HW'(H_ACTIVE + H_FRONT);
  localparam logic [HW-1:0] H_SYNC_END = HW'(H_ACTIVE + H_FRONT + H_SYNC);
  localparam logic [VW-1:0] V_VIS_END  = VW'(V_ACTIVE);
  localparam logic [VW-1:0] V_SYNC_BEG = VW'(V_ACTIVE + V_FRONT);
  localparam logic [VW-1:0] V_SYNC_END = VW'(V_ACTIVE + V_FRONT + V_SYNC);

  always_comb begin
    activeFlag = (hPos < H_VIS_END) && (vPos < V_VIS_END);
    hSyncFlag  = (hPos >= H_SYNC_BEG) && (hPos < H_SYNC_END);
    vSyncFlag  = (vPos >= V_SYNC_BEG) && (vPos < V_SYNC_END);
  end
endmodule

// File: rtl/raster_datapath.sv
module raster_datapath
  import video_timing_pkg::*;
#(
  parameter int HW       = 11,
  parameter int VW       = 10,
  parameter int FW       = 6,
  parameter int H_ACTIVE = 1280,
  parameter int H_FRONT  = 110,
  parameter int H_SYNC   = 40,
  parameter int V_ACTIVE = 720,
  parameter int V_FRONT  = 5,
  parameter int V_SYNC   = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  rasterStrobes_t strobes,
  output logic [HW-1:0]  hCount,
  output logic [VW-1:0]  vCount,
  output logic [FW-1:0]  frameCount,
  output logic           hSync,
  output logic           vSync,
  output logic           activeDraw,
  output logic           newFrame
);
  logic [HW-1:0] hNext;
  logic [VW-1:0] vNext;
  logic [FW-1:0] fNext;
  logic          wrapNext;
  logic          activeNext, hSyncNext, vSyncNext;

  // next raster position, driven by control strobes
  always_comb begin
    hNext    = strobes.hEnd ? '0 : hCount + 1'b1;
    vNext    = vCount;
    fNext    = frameCount;
    wrapNext = strobes.hEnd && strobes.vEnd;
    if (strobes.hEnd) vNext = strobes.vEnd ? '0 : vCount + 1'b1;
    if (wrapNext)     fNext = strobes.fEnd ? '0 : frameCount + 1'b1;
  end

  // flags decoded from the next position so they align with the counters
  raster_decode #(
    .HW(HW), .VW(VW),
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC)
  ) u_decode (
    .hPos(hNext),
    .vPos(vNext),
    .activeFlag(activeNext),
    .hSyncFlag(hSyncNext),
    .vSyncFlag(vSyncNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount     <= '0;
      vCount     <= '0;
      frameCount <= '0;
      hSync      <= 1'b0;
      vSync      <= 1'b0;
      activeDraw <= 1'b0;
      newFrame   <= 1'b0;
    end else begin
      hCount     <= hNext;
      vCount     <= vNext;
      frameCount <= fNext;
      hSync      <= hSyncNext;
      vSync      <= vSyncNext;
      activeDraw <= activeNext;
      newFrame   <= wrapNext;
    end
  end
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import video_timing_pkg::*;
#(
  parameter int HW        = 11,
  parameter int VW        = 10,
  parameter int FW        = 6,
  parameter int H_ACTIVE  = 1280,
  parameter int H_FRONT   = 110,
  parameter int H_SYNC    = 40,
  parameter int H_BACK    = 220,
  parameter int V_ACTIVE  = 720,
  parameter int V_FRONT   = 5,
  parameter int V_SYNC    = 5,
  parameter int V_BACK    = 20,
  parameter int FRAME_MOD = 60
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hCount,
  output logic [VW-1:0] vCount,
  output logic          hSync,
  output logic          vSync,
  output logic          activeDraw,
  output logic          newFrame,
  output logic [FW-1:0] frameCount
);
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;

  rasterStrobes_t strobes;

  raster_ctrl #(
    .HW(HW), .VW(VW), .FW(FW),
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .FRAME_MOD(FRAME_MOD)
  ) u_ctrl (
    .hCount(hCount),
    .vCount(vCount),
    .frameCount(frameCount),
    .strobes(strobes)
  );

  raster_datapath #(
    .HW(HW), .VW(VW), .FW(FW),
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC)
  ) u_dp (
    .clk(clk),
    .rst(rst),
    .strobes(strobes),
    .hCount(hCount),
    .vCount(vCount),
    .frameCount(frameCount),
    .hSync(hSync),
    .vSync(vSync),
    .activeDraw(activeDraw),
    .newFrame(newFrame)
  );
endmodule

// File: rtl/video_timing_checks.sv
module video_timing_checks #(
  parameter int HW        = 11,
  parameter int VW        = 10,
  parameter int FW        = 6,
  parameter int H_ACTIVE  = 1280,
  parameter int H_TOTAL   = 1650,
  parameter int V_ACTIVE  = 720,
  parameter int V_TOTAL   = 750,
  parameter int FRAME_MOD = 60
) (
  input logic          clk,
  input logic          rst,
  input logic [HW-1:0] hCount,
  input logic [VW-1:0] vCount,
  input logic          activeDraw,
  input logic          newFrame,
  input logic [FW-1:0] frameCount
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [FW-1:0] F_LAST = FW'(FRAME_MOD - 1);

  p_hwrap_r2: assert property (@(posedge clk) disable iff (rst)
    (hCount == H_LAST) |=> (hCount == '0));

  p_hstep_r2: assert property (@(posedge clk) disable iff (rst)
    (hCount != H_LAST) |=> (hCount == $past(hCount) + 1'b1));

  p_vhold_r3: assert property (@(posedge clk) disable iff (rst)
    (hCount != H_LAST) |=> $stable(vCount));

  p_active_region_r4: assert property (@(posedge clk) disable iff (rst)
    activeDraw |-> (hCount < HW'(H_ACTIVE)) && (vCount < VW'(V_ACTIVE)));

  p_newframe_origin_r7: assert property (@(posedge clk) disable iff (rst)
    newFrame |-> (hCount == '0) && (vCount == '0));

  p_frame_step_r8: assert property (@(posedge clk) disable iff (rst)
    newFrame |-> (frameCount == (($past(frameCount) == F_LAST) ? '0 : $past(frameCount) + 1'b1)));

  p_frame_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !newFrame |-> (frameCount == $past(frameCount)));

  p_frame_range_r8: assert property (@(posedge clk) disable iff (rst)
    frameCount < FW'(FRAME_MOD));
endmodule

bind video_timing_gen video_timing_checks #(
  .HW(HW), .VW(VW), .FW(FW),
  .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL),
  .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL), .FRAME_MOD(FRAME_MOD)
) u_checks (
  .clk(clk),
  .rst(rst),
  .hCount(hCount),
  .vCount(vCount),
  .activeDraw(activeDraw),
  .newFrame(newFrame),
  .frameCount(frameCount)
);

// File: tb/video_timing_gen_test.sv
module video_timing_gen_test;
  localparam int HA = 16, HF = 2, HS = 3, HB = 4;
  localparam int VA = 8,  VF = 1, VS = 2, VB = 3;
  localparam int FM = 60;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FT = HT * VT;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] hCount;
  logic [9:0]  vCount;
  logic        hSync, vSync, activeDraw, newFrame;
  logic [5:0]  frameCount;

  int vectors = 0;
  int fails   = 0;
  int k       = 0;   // clock edges since reset release

  always #4 clk = ~clk;  // 125 MHz

  video_timing_gen #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .FRAME_MOD(FM)
  ) uut (
    .clk(clk), .rst(rst),
    .hCount(hCount), .vCount(vCount),
    .hSync(hSync), .vSync(vSync),
    .activeDraw(activeDraw), .newFrame(newFrame),
    .frameCount(frameCount)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at k=%0d: actual %0d expected %0d", req, what, k, act, exp);
    end
  endtask

  task automatic checkReset();
    check("R1", "hCount", int'(hCount), 0);
    check("R1", "vCount", int'(vCount), 0);
    check("R1", "frameCount", int'(frameCount), 0);
    check("R1", "hSync", int'(hSync), 0);
    check("R1", "vSync", int'(vSync), 0);
    check("R1", "activeDraw", int'(activeDraw), 0);
    check("R1", "newFrame", int'(newFrame), 0);
  endtask

  task automatic applyReset(input int n);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkReset();
    end
    rst = 1'b0;
    k = 0;
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) begin
      int p, h, v;
      @(posedge clk);
      k++;
      @(negedge clk);
      p = k % FT;
      h = p % HT;
      v = p / HT;
      check("R2", "hCount", int'(hCount), h);
      check("R3", "vCount", int'(vCount), v);
      check("R4", "activeDraw", int'(activeDraw), int'(h < HA && v < VA));
      check("R5", "hSync", int'(hSync), int'(h >= HA + HF && h < HA + HF + HS));
      check("R6", "vSync", int'(vSync), int'(v >= VA + VF && v < VA + VF + VS));
      check("R7", "newFrame", int'(newFrame), int'(p == 0));
      check("R8", "frameCount", int'(frameCount), (k / FT) % FM);
    end
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    applyReset(4);
    runCycles(FT * 2 + 37);      // R7: wrap pulses; then reset mid-frame
    applyReset(3);               // R1 mid-run: 0,0 without newFrame
    runCycles(FT * (FM + 1) + 5); // R8: full 0..59 cycle and wrap to 0
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule